// File: doc/BRIEF.md
# Serial Transmitter with Break and Idle Framing

This block is the sending half of an asynchronous serial port. Software-side logic writes a data word through a write strobe. If the line is free the word starts at once. If a frame is already on the line, the word waits in a one-word holding buffer and follows back to back. A shift register clocked by an external baud tick sends each frame as a low start bit, the data bits least significant first, and a single high stop bit. Words are 8 bits wide, or 9 bits wide when the ninth bit comes from a configuration input.

Two status flags track the transmitter: one for "holding buffer empty" and one for "frame complete". Each flag can raise the interrupt output through its own enable. A flag is cleared only when a status read strobe is followed later by a data write. Enabling the transmitter sends one all-ones idle frame first. Turning the enable off and on again in the middle of a frame queues an idle frame after that frame and drops any buffered word. While the break control is held, break frames of all zeros go out back to back. When it is released, one high bit is sent before anything else. In the bus-master break mode used by single-wire automotive buses, a break frame is 13 low bits long.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset the serial output is high, both flags are set and the interrupt output is low.
- R2: With cfg_nine low a data frame is 10 bit periods: one low start bit, the 8 data bits with bit 0 first, and one high stop bit. Each bit period ends on a baud tick.
- R3: With cfg_nine high a data frame is 11 bit periods. The cfg_bit9 value is sent after data bit 7 and before the stop bit.
- R4: A data write while enabled, not shifting and with nothing pending starts the frame in the current bit period. The buffer-empty flag is still set afterwards, even when the flags were armed.
- R5: A data write during a frame goes to the holding buffer. The buffered word is sent with no gap after the current frame ends, and the buffer-empty flag is set when the word moves into the shift register.
- R6: Both flags are cleared by a data write only if a status read came before it since the last data write. A data write with no such read leaves them unchanged.
- R7: The frame-complete flag is set at the end of every frame, whether data, idle, break or mark.
- R8: irq is high exactly when (flag_empty and ie_empty) or (flag_done and ie_done), with no added latency in the default configuration.
- R9: A rising edge of cfg_en sends one idle frame (all ones, the length of a data frame) before anything else. It also discards the buffered word and sets the buffer-empty flag.
- R10: No frame starts while cfg_en is low, and the line stays high when no frame is being shifted.
- R11: While cfg_brk is high, all-zero break frames of data-frame length go out back to back. They take priority over a buffered word.
- R12: After cfg_brk falls, the transmitter finishes the current break frame, sends one high bit, and then sends any pending word.
- R13: With cfg_lin high, one break frame is 13 low bit periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Single-cycle pulse, one per bit period |
| cfg_en | input | 1 | Transmitter enable |
| cfg_nine | input | 1 | 9-bit word length when high |
| cfg_bit9 | input | 1 | Ninth data bit, sampled with the data write |
| cfg_brk | input | 1 | Send break frames while high |
| cfg_lin | input | 1 | Break frame of 13 bits when high |
| ie_empty | input | 1 | Interrupt enable for the buffer-empty flag |
| ie_done | input | 1 | Interrupt enable for the frame-complete flag |
| wr_data | input | 1 | Data register write strobe |
| wr_value | input | DATA_W | Data word written |
| rd_status | input | 1 | Status register read strobe (arms flag clearing) |
| txd | output | 1 | Serial data output |
| irq | output | 1 | Interrupt request |
| flag_empty | output | 1 | Holding buffer empty flag |
| flag_done | output | 1 | Frame complete flag |

## Verification
The hardest cases to reach are the ones where two frame sources compete at a frame boundary. One is an enable toggle in the middle of a frame while a word sits in the buffer. The other is a break released with a word queued behind it, where the single mark bit has to come between the last break frame and the data. The bench syncs every stimulus to the tick that ends a bit period. A recorder stores the line level once per bit period, so the exact position of each idle frame, mark bit or discarded word can be compared bit for bit against the expected stream.

// File: rtl/txb_pkg.sv
package txb_pkg;
   typedef enum logic [1:0] {
      FK_DATA = 2'd0,
      FK_IDLE = 2'd1,
      FK_BRK  = 2'd2,
      FK_MARK = 2'd3
   } frame_kind_e;
endpackage

// File: rtl/txb_shift.sv
module txb_shift #(
   parameter int SR_W  = 13,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [SR_W-1:0]  load_bits,
   input  logic [CNT_W-1:0] load_len,
   output logic             busy,
   output logic             frame_end,
   output logic             txd
);
   logic [SR_W-1:0]  sreg;
   logic [CNT_W-1:0] left;

   assign frame_end = busy & tick & (left == CNT_W'(1));
   assign txd       = busy ? sreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '1;
         left <= '0;
         busy <= 1'b0;
      end else if (load) begin
         sreg <= load_bits;
         left <= load_len;
         busy <= 1'b1;
      end else if (busy && tick) begin
         sreg <= {1'b1, sreg[SR_W-1:1]};
         left <= left - CNT_W'(1);
         if (left == CNT_W'(1)) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/txb_seq.sv
module txb_seq
   import txb_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int LIN_BRK_LEN = 13,
   parameter int SR_W        = 13,
   parameter int CNT_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_nine,
   input  logic              cfg_bit9,
   input  logic              cfg_brk,
   input  logic              cfg_lin,
   input  logic              wr_data,
   input  logic [DATA_W-1:0] wr_value,
   input  logic              busy,
   input  logic              frame_end,
   output logic              load,
   output logic [SR_W-1:0]   load_bits,
   output logic [CNT_W-1:0]  load_len,
   output logic              took_word,
   output logic              te_rise
);
   localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(DATA_W + 2);
   localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(DATA_W + 3);
   localparam logic [CNT_W-1:0] LEN_LIN   = CNT_W'(LIN_BRK_LEN);
   localparam logic [CNT_W-1:0] LEN_ONE   = CNT_W'(1);

   logic              en_q, idle_req, brk_sent, buf_full, buf_b9;
   logic [DATA_W-1:0] buf_val;
   logic              idle_pend, room, take_buf, take_direct;
   logic [DATA_W-1:0] src_val;
   logic              src_b9;
   frame_kind_e       kind;

   assign te_rise   = cfg_en & ~en_q;
   assign idle_pend = idle_req | te_rise;
   assign room      = cfg_en & (~busy | frame_end);
   assign took_word = take_buf | take_direct;
   assign src_val   = take_direct ? wr_value : buf_val;
   assign src_b9    = take_direct ? cfg_bit9 : buf_b9;

   // frame source priority: idle, break, mark, buffered word, direct write
   always_comb begin
      load        = 1'b0;
      kind        = FK_IDLE;
      take_buf    = 1'b0;
      take_direct = 1'b0;
      if (room) begin
         if (idle_pend) begin
            load = 1'b1; kind = FK_IDLE;
         end else if (cfg_brk) begin
            load = 1'b1; kind = FK_BRK;
         end else if (brk_sent) begin
            load = 1'b1; kind = FK_MARK;
         end else if (buf_full) begin
            load = 1'b1; kind = FK_DATA; take_buf = 1'b1;
         end else if (wr_data) begin
            load = 1'b1; kind = FK_DATA; take_direct = 1'b1;
         end
      end
   end

   always_comb begin
      load_bits = '1;
      load_len  = cfg_nine ? LEN_LONG : LEN_SHORT;
      case (kind)
         FK_DATA: begin
            load_bits[0]        = 1'b0;
            load_bits[DATA_W:1] = src_val;
            if (cfg_nine) load_bits[DATA_W+1] = src_b9;
         end
         FK_BRK: begin
            load_bits = '0;
            if (cfg_lin) load_len = LEN_LIN;
         end
         FK_MARK: load_len = LEN_ONE;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         idle_req <= 1'b0;
         brk_sent <= 1'b0;
         buf_full <= 1'b0;
         buf_b9   <= 1'b0;
         buf_val  <= '0;
      end else begin
         en_q <= cfg_en;
         if (load && kind == FK_IDLE)  idle_req <= 1'b0;
         else if (te_rise)             idle_req <= 1'b1;
         if (load && kind == FK_BRK)       brk_sent <= 1'b1;
         else if (load && kind == FK_MARK) brk_sent <= 1'b0;
         if (wr_data && !take_direct) begin
            buf_val  <= wr_value;
            buf_b9   <= cfg_bit9;
            buf_full <= 1'b1;
         end else if (take_buf || te_rise) begin
            buf_full <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/txb_flags.sv
module txb_flags #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_status,
   input  logic wr_data,
   input  logic set_empty,
   input  logic set_done,
   input  logic ie_empty,
   input  logic ie_done,
   output logic flag_empty,
   output logic flag_done,
   output logic irq
);
   logic armed, clr, irq_raw;

   assign clr     = armed & wr_data;
   assign irq_raw = (flag_empty & ie_empty) | (flag_done & ie_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         flag_empty <= 1'b1;
         flag_done  <= 1'b1;
      end else begin
         if (rd_status)    armed <= 1'b1;
         else if (wr_data) armed <= 1'b0;
         if (set_empty) flag_empty <= 1'b1;
         else if (clr)  flag_empty <= 1'b0;
         if (set_done)  flag_done <= 1'b1;
         else if (clr)  flag_done <= 1'b0;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
   parameter int DATA_W      = 8,
   parameter int LIN_BRK_LEN = 13,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              cfg_en,
   input  logic              cfg_nine,
   input  logic              cfg_bit9,
   input  logic              cfg_brk,
   input  logic              cfg_lin,
   input  logic              ie_empty,
   input  logic              ie_done,
   input  logic              wr_data,
   input  logic [DATA_W-1:0] wr_value,
   input  logic              rd_status,
   output logic              txd,
   output logic              irq,
   output logic              flag_empty,
   output logic              flag_done
);
   localparam int FRM_W = DATA_W + 3;
   localparam int SR_W  = (FRM_W > LIN_BRK_LEN) ? FRM_W : LIN_BRK_LEN;
   localparam int CNT_W = $clog2(SR_W + 1);

   if (DATA_W < 5) begin : g_bad_width
      $error("uart_tx_brk: DATA_W must be at least 5");
   end
   if (LIN_BRK_LEN < DATA_W + 2) begin : g_bad_brk
      $error("uart_tx_brk: LIN_BRK_LEN shorter than a data frame");
   end

   logic              load_w, busy_w, fend_w, took_w, rise_w;
   logic [SR_W-1:0]   bits_w;
   logic [CNT_W-1:0]  len_w;

   txb_seq #(
      .DATA_W(DATA_W), .LIN_BRK_LEN(LIN_BRK_LEN), .SR_W(SR_W), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_nine(cfg_nine),
      .cfg_bit9(cfg_bit9), .cfg_brk(cfg_brk), .cfg_lin(cfg_lin),
      .wr_data(wr_data), .wr_value(wr_value), .busy(busy_w),
      .frame_end(fend_w), .load(load_w), .load_bits(bits_w),
      .load_len(len_w), .took_word(took_w), .te_rise(rise_w)
   );

   txb_shift #(.SR_W(SR_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(load_w),
      .load_bits(bits_w), .load_len(len_w), .busy(busy_w),
      .frame_end(fend_w), .txd(txd)
   );

   txb_flags #(.IRQ_REG(IRQ_REG)) u_flags (
      .clk(clk), .rst_n(rst_n), .rd_status(rd_status), .wr_data(wr_data),
      .set_empty(took_w | rise_w), .set_done(fend_w),
      .ie_empty(ie_empty), .ie_done(ie_done),
      .flag_empty(flag_empty), .flag_done(flag_done), .irq(irq)
   );
endmodule

// File: rtl/txb_checker.sv
module txb_checker (
   input logic clk,
   input logic rst_n,
   input logic cfg_en,
   input logic wr_data,
   input logic flag_empty,
   input logic flag_done,
   input logic busy,
   input logic frame_end
);
   // R6
   done_clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_done) |-> $past(wr_data));
   // R6
   empty_clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_empty) |-> $past(wr_data));
   // R7
   done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> flag_done);
   // R10
   start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cfg_en));
   // R9
   idle_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cfg_en) && !busy) |=> busy);
endmodule

bind uart_tx_brk txb_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .wr_data(wr_data),
   .flag_empty(flag_empty), .flag_done(flag_done),
   .busy(busy_w), .frame_end(fend_w)
);

// File: tb/sim_uart_tx_brk.sv
module sim_uart_tx_brk;
   localparam int BP = 8;

   logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
   logic cfg_en = 1'b0, cfg_nine = 1'b0, cfg_bit9 = 1'b0, cfg_brk = 1'b0, cfg_lin = 1'b0;
   logic ie_empty = 1'b0, ie_done = 1'b0, wr_data = 1'b0, rd_status = 1'b0;
   logic [7:0] wr_value = 8'h00;
   logic txd, irq, flag_empty, flag_done;

   int n_chk = 0, n_bad = 0, tcnt = 0, sp = 0;
   logic stream [0:255];

   uart_tx_brk u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_en(cfg_en),
      .cfg_nine(cfg_nine), .cfg_bit9(cfg_bit9), .cfg_brk(cfg_brk), .cfg_lin(cfg_lin),
      .ie_empty(ie_empty), .ie_done(ie_done), .wr_data(wr_data), .wr_value(wr_value),
      .rd_status(rd_status), .txd(txd), .irq(irq), .flag_empty(flag_empty),
      .flag_done(flag_done)
   );

   initial forever #10 clk = ~clk;

   initial forever begin
      @(posedge clk);
      tcnt      <= (tcnt == BP - 1) ? 0 : tcnt + 1;
      baud_tick <= (tcnt == BP - 2);
   end

   // one entry per bit period: the level held just before the closing tick
   initial forever begin
      @(negedge clk);
      if (baud_tick) begin
         stream[sp[7:0]] = txd;
         sp++;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   function automatic logic [31:0] f8(input logic [7:0] d);
      return {22'h0, 1'b1, d, 1'b0};
   endfunction
   function automatic logic [31:0] f9(input logic [7:0] d, input logic b9);
      return {21'h0, 1'b1, b9, d, 1'b0};
   endfunction
   function automatic logic [31:0] ones(input int n);
      return (32'h1 << n) - 32'h1;
   endfunction

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic chk_stream(input int first, input int n, input logic [31:0] exp, input string what);
      logic [31:0] got;
      got = '0;
      for (int i = 0; i < n; i++) got[i] = stream[(first + i) % 256];
      chk(got == exp, what, got, exp);
   endtask

   task automatic wait_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         do @(negedge clk); while (!baud_tick);
      end
      @(negedge clk);
   endtask

   task automatic mark();
      sp = 0;
   endtask

   task automatic pulse_wr(input logic [7:0] v);
      wr_value = v;
      wr_data  = 1'b1;
      @(negedge clk);
      wr_data  = 1'b0;
   endtask

   task automatic pulse_rd();
      rd_status = 1'b1;
      @(negedge clk);
      rd_status = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd == 1'b1, "R1 txd after reset", txd, 1);
      chk(flag_empty && flag_done, "R1 flags after reset", {flag_empty, flag_done}, 2'b11);
      chk(irq == 1'b0, "R1 irq after reset", irq, 0);
   endtask

   task automatic t_idle_first();
      wait_ticks(1);
      mark();
      cfg_en = 1'b1;
      pulse_wr(8'hA5);
      wait_ticks(22);
      chk_stream(0, 10, ones(10), "R9 idle frame before first word");
      chk_stream(10, 10, f8(8'hA5), "R2 8-bit frame 0xA5");
      chk_stream(20, 2, ones(2), "R10 line high when nothing pending");
      chk(flag_done == 1'b1, "R7 done after frame", flag_done, 1);
   endtask

   task automatic t_direct();
      wait_ticks(1);
      mark();
      pulse_rd();
      pulse_wr(8'h3C);
      chk(flag_empty == 1'b1, "R4 empty stays set on direct start", flag_empty, 1);
      chk(flag_done == 1'b0, "R6 armed write clears done", flag_done, 0);
      wait_ticks(12);
      chk_stream(0, 10, f8(8'h3C), "R4 direct frame starts at once");
      chk(flag_done == 1'b1, "R7 done set at frame end", flag_done, 1);
   endtask

   task automatic t_buffered();
      wait_ticks(1);
      mark();
      pulse_wr(8'h11);
      pulse_rd();
      pulse_wr(8'h82);
      chk(flag_empty == 1'b0, "R5 empty cleared by buffered write", flag_empty, 0);
      wait_ticks(10);
      chk(flag_empty == 1'b1, "R5 empty set when buffer copied", flag_empty, 1);
      wait_ticks(12);
      chk_stream(0, 10, f8(8'h11), "R5 first frame");
      chk_stream(10, 10, f8(8'h82), "R5 buffered frame back to back");
   endtask

   task automatic t_nine();
      cfg_nine = 1'b1;
      wait_ticks(1);
      mark();
      cfg_bit9 = 1'b1;
      pulse_wr(8'h0F);
      wait_ticks(13);
      chk_stream(0, 11, f9(8'h0F, 1'b1), "R3 9-bit frame bit9=1");
      mark();
      cfg_bit9 = 1'b0;
      pulse_wr(8'hF0);
      wait_ticks(13);
      chk_stream(0, 11, f9(8'hF0, 1'b0), "R3 9-bit frame bit9=0");
      cfg_nine = 1'b0;
   endtask

   task automatic t_flags_irq();
      wait_ticks(1);
      pulse_wr(8'h00);
      chk(flag_done == 1'b1, "R6 write without read keeps done", flag_done, 1);
      wait_ticks(12);
      ie_done = 1'b1;
      pulse_rd();
      pulse_wr(8'hFF);
      chk(irq == 1'b0, "R8 irq low while done clear", irq, 0);
      wait_ticks(12);
      chk(irq == 1'b1, "R8 irq from done flag", irq, 1);
      ie_done = 1'b0;
      ie_empty = 1'b1;
      @(negedge clk);
      chk(irq == 1'b1, "R8 irq from empty flag", irq, 1);
      ie_empty = 1'b0;
      @(negedge clk);
      chk(irq == 1'b0, "R8 irq masked by enables", irq, 0);
   endtask

   task automatic t_break();
      wait_ticks(1);
      mark();
      cfg_brk = 1'b1;
      pulse_wr(8'h96);
      wait_ticks(15);
      cfg_brk = 1'b0;
      wait_ticks(18);
      chk_stream(0, 20, 32'h0, "R11 two back-to-back break frames");
      chk_stream(20, 1, 32'h1, "R12 mark bit after break");
      chk_stream(21, 10, f8(8'h96), "R12 pending word after mark");
   endtask

   task automatic t_lin_break();
      cfg_lin = 1'b1;
      wait_ticks(1);
      mark();
      cfg_brk = 1'b1;
      pulse_wr(8'h5A);
      wait_ticks(5);
      cfg_brk = 1'b0;
      wait_ticks(21);
      chk_stream(0, 13, 32'h0, "R13 13-bit break");
      chk_stream(13, 1, 32'h1, "R12 mark after long break");
      chk_stream(14, 10, f8(8'h5A), "R13 word after long break");
      cfg_lin = 1'b0;
   endtask

   task automatic t_te_toggle();
      wait_ticks(1);
      mark();
      pulse_wr(8'h55);
      pulse_rd();
      pulse_wr(8'h33);
      chk(flag_empty == 1'b0, "R5 empty clear with word buffered", flag_empty, 0);
      wait_ticks(3);
      cfg_en = 1'b0;
      @(negedge clk);
      cfg_en = 1'b1;
      @(negedge clk);
      chk(flag_empty == 1'b1, "R9 empty set on buffer discard", flag_empty, 1);
      wait_ticks(27);
      chk_stream(0, 10, f8(8'h55), "R9 current word completes");
      chk_stream(10, 20, ones(20), "R9 idle frame, buffered word dropped");
   endtask

   task automatic t_disabled();
      wait_ticks(1);
      mark();
      cfg_en = 1'b0;
      pulse_wr(8'h00);
      wait_ticks(12);
      chk_stream(0, 12, ones(12), "R10 no frame while disabled");
      chk(txd == 1'b1, "R10 line high while disabled", txd, 1);
      mark();
      cfg_en = 1'b1;
      wait_ticks(22);
      chk_stream(0, 22, ones(22), "R9 enable drops word written while off");
   endtask

   initial begin
      t_reset();
      t_idle_first();
      t_direct();
      t_buffered();
      t_nine();
      t_flags_irq();
      t_break();
      t_lin_break();
      t_te_toggle();
      t_disabled();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule